// File: doc/BRIEF.md
# Burst Address Sequencer with Order Select

This block produces the address sequence for a four-beat burst. A starting address is captured whenever either of two active-low address strobes is asserted. One strobe belongs to a processor and the other to a cache controller, and both behave the same way. Only the low two address bits change during the burst. The upper bits are held exactly as they were loaded.

On every clock where the active-low advance input is asserted, the low bits step to the next beat. A static order-select input picks the stepping rule:
- **Interleaved:** the low bits are the start bits XOR the beat count.
- **Linear:** the low bits are the start bits plus the beat count, modulo four.

After the fourth beat the sequence returns to the starting offset and the beat count returns to zero. The block outputs the current burst address and the beat index. It is meant to sit in front of a synchronous memory array, feeding its word address during burst accesses.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising edge, `addr_out` and `beat_idx` become zero on that edge.
- R2: A rising edge with `strb_cpu_n` low loads `addr_in` into `addr_out` and sets `beat_idx` to 0.
- R3: A rising edge with `strb_cache_n` low (and `strb_cpu_n` high) loads `addr_in` into `addr_out` and sets `beat_idx` to 0, just as R2.
- R4: With `order_sel` = 1 (interleaved), each advance sets the low two bits of `addr_out` to start XOR k, where k is the new `beat_idx`. Examples: start 01 gives 01,00,11,10; start 11 gives 11,10,01,00.
- R5: With `order_sel` = 0 (linear), each advance sets the low two bits to (start + k) mod 4. Examples: start 01 gives 01,10,11,00; start 11 gives 11,00,01,10.
- R6: Each advance increments `beat_idx` modulo 4. The fourth advance after a load returns the low bits to the starting offset and `beat_idx` to 0.
- R7: A rising edge with `adv_n` high and no strobe leaves `addr_out` and `beat_idx` unchanged.
- R8: When a strobe and `adv_n` are both low at the same edge, the load wins. The result is the new address with `beat_idx` 0.
- R9: The upper address bits (all but the low two) change only on a load, never on an advance or a hold.
- R10: A change of `order_sel` in the middle of a burst has no immediate effect on `addr_out`. The next advance applies the new order to the starting offset and the incremented beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_cpu_n | input | 1 | Active-low address strobe from the processor side |
| strb_cache_n | input | 1 | Active-low address strobe from the cache-controller side |
| adv_n | input | 1 | Active-low burst advance |
| order_sel | input | 1 | Beat order: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | Starting address captured on a strobe |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | BEAT_BITS | Beat count since the last load (0..3) |

## Verification
The hardest case to reach is a change of order in the middle of a burst. A switch at beat two is invisible, because adding two and XOR-ing with two give the same low bits. The stimulus therefore advances twice in linear order from start 01, flips `order_sel`, checks that the output holds, and then advances to beat three. There the two orders differ: 10 for interleaved against 00 for linear. Load-over-advance priority is reached by asserting a strobe together with the advance in the middle of a burst, with a new address whose upper bits differ.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bsq_strobe_decode.sv
module bsq_strobe_decode (
  input  logic strb_cpu_n,
  input  logic strb_cache_n,
  input  logic adv_n,
  output logic load_evt,
  output logic adv_evt
);
  // Either strobe loads; advance only counts when no load is present.
  always_comb begin
    load_evt = !strb_cpu_n || !strb_cache_n;
    adv_evt  = !adv_n && !load_evt;
  end
endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter #(
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_evt,
  input  logic                 adv_evt,
  output logic [BEAT_BITS-1:0] beat_q,
  output logic [BEAT_BITS-1:0] beat_nxt
);
  function automatic logic [BEAT_BITS-1:0] bump(input logic [BEAT_BITS-1:0] b);
    return b + BEAT_BITS'(1);
  endfunction

  always_comb beat_nxt = bump(beat_q);

  always_ff @(posedge clk) begin
    if (rst)           beat_q <= '0;
    else if (load_evt) beat_q <= '0;
    else if (adv_evt)  beat_q <= beat_nxt;
  end
endmodule

// File: rtl/bsq_offset_gen.sv
module bsq_offset_gen
  import bsq_pkg::*;
#(
  parameter int BEAT_BITS = 2
) (
  input  logic [BEAT_BITS-1:0] start_off,
  input  logic [BEAT_BITS-1:0] beat,
  input  order_e               order,
  output logic [BEAT_BITS-1:0] offset
);
  logic [BEAT_BITS-1:0] ilv_off;
  logic [BEAT_BITS-1:0] lin_off;

  function automatic logic [BEAT_BITS-1:0] lin_step(
    input logic [BEAT_BITS-1:0] s,
    input logic [BEAT_BITS-1:0] k
  );
    return s + k;
  endfunction

  // Interleaved order: every bit toggles independently.
  for (genvar i = 0; i < BEAT_BITS; i++) begin : g_ilv
    assign ilv_off[i] = start_off[i] ^ beat[i];
  end

  always_comb begin
    lin_off = lin_step(start_off, beat);
    offset  = (order == ORD_INTERLEAVE) ? ilv_off : lin_off;
  end
endmodule

// File: rtl/bsq_addr_reg.sv
module bsq_addr_reg #(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2,
  localparam int UPPER_W  = ADDR_W - BEAT_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_evt,
  input  logic                 adv_evt,
  input  logic [ADDR_W-1:0]    addr_in,
  input  logic [BEAT_BITS-1:0] next_off,
  output logic [UPPER_W-1:0]   upper_q,
  output logic [BEAT_BITS-1:0] start_q,
  output logic [BEAT_BITS-1:0] low_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
      low_q   <= '0;
    end else if (load_evt) begin
      upper_q <= addr_in[ADDR_W-1:BEAT_BITS];
      start_q <= addr_in[BEAT_BITS-1:0];
      low_q   <= addr_in[BEAT_BITS-1:0];
    end else if (adv_evt) begin
      low_q   <= next_off;
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strb_cpu_n,
  input  logic                 strb_cache_n,
  input  logic                 adv_n,
  input  logic                 order_sel,
  input  logic [ADDR_W-1:0]    addr_in,
  output logic [ADDR_W-1:0]    addr_out,
  output logic [BEAT_BITS-1:0] beat_idx
);
  localparam int UPPER_W = ADDR_W - BEAT_BITS;

  // Named internal events, also observed by the checker.
  logic                 load_evt;
  logic                 adv_evt;
  logic [BEAT_BITS-1:0] beat_nxt;
  logic [BEAT_BITS-1:0] start_off;
  logic [BEAT_BITS-1:0] next_off;
  logic [BEAT_BITS-1:0] low_off;
  logic [UPPER_W-1:0]   upper_q;
  order_e               order;

  assign order = order_e'(order_sel);

  bsq_strobe_decode u_dec (
    .strb_cpu_n   (strb_cpu_n),
    .strb_cache_n (strb_cache_n),
    .adv_n        (adv_n),
    .load_evt     (load_evt),
    .adv_evt      (adv_evt)
  );

  bsq_beat_counter #(.BEAT_BITS(BEAT_BITS)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .beat_q   (beat_idx),
    .beat_nxt (beat_nxt)
  );

  bsq_offset_gen #(.BEAT_BITS(BEAT_BITS)) u_off (
    .start_off (start_off),
    .beat      (beat_nxt),
    .order     (order),
    .offset    (next_off)
  );

  bsq_addr_reg #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .addr_in  (addr_in),
    .next_off (next_off),
    .upper_q  (upper_q),
    .start_q  (start_off),
    .low_q    (low_off)
  );

  assign addr_out = {upper_q, low_off};
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 load_evt,
  input logic                 adv_evt,
  input logic                 order_sel,
  input logic [ADDR_W-1:0]    addr_in,
  input logic [ADDR_W-1:0]    addr_out,
  input logic [BEAT_BITS-1:0] beat_idx,
  input logic [BEAT_BITS-1:0] start_off
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && (beat_idx == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (addr_out == $past(addr_in)) && (beat_idx == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!load_evt && !adv_evt) |=> $stable(addr_out) && $stable(beat_idx));

  p_upper_r9: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> addr_out[ADDR_W-1:BEAT_BITS] == $past(addr_out[ADDR_W-1:BEAT_BITS]));

  p_beat_step_r6: assert property (@(posedge clk) disable iff (rst)
    adv_evt |=> beat_idx == BEAT_BITS'($past(beat_idx) + BEAT_BITS'(1)));

  p_ilv_r4: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && order_sel) |=>
      addr_out[BEAT_BITS-1:0] == ($past(start_off) ^ beat_idx));

  p_lin_r5: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && !order_sel) |=>
      addr_out[BEAT_BITS-1:0] == BEAT_BITS'($past(start_off) + beat_idx));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && beat_idx == '1) |=> addr_out[BEAT_BITS-1:0] == start_off);
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_bsq_chk (
  .clk       (clk),
  .rst       (rst),
  .load_evt  (load_evt),
  .adv_evt   (adv_evt),
  .order_sel (order_sel),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .beat_idx  (beat_idx),
  .start_off (start_off)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/100ps
module test_burst_addr_seq;
  localparam int AW = 17;
  localparam int BB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strb_cpu_n = 1'b1;
  logic          strb_cache_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [BB-1:0] beat_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_BITS(BB)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .strb_cpu_n(strb_cpu_n), .strb_cache_n(strb_cache_n),
    .adv_n(adv_n), .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out), .beat_idx(beat_idx)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_low(input logic [1:0] s, input int k, input logic ilv);
    int v;
    if (ilv) v = s ^ (k % 4);
    else     v = (s + k) % 4;
    return v[1:0];
  endfunction

  task automatic do_load(input logic use_cache, input logic [AW-1:0] a, input logic adv);
    addr_in = a;
    if (use_cache) strb_cache_n = 1'b0; else strb_cpu_n = 1'b0;
    adv_n = !adv;
    cyc();
    strb_cpu_n = 1'b1;
    strb_cache_n = 1'b1;
    adv_n = 1'b1;
  endtask

  task automatic do_adv();
    adv_n = 1'b0;
    cyc();
    adv_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc();
    cyc();
    chk("R1 addr", addr_out, '0);
    chk("R1 beat", AW'(beat_idx), '0);
    rst = 1'b0;
    cyc();

    // Sweep both orders, all four offsets, two full wraps each.
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] base;
        base = AW'((s * 'h1357 + m * 'h0a5c) << 2) | AW'(s);
        order_sel = m[0];
        do_load(s[0], base, 1'b0);
        chk(s[0] ? "R3 load" : "R2 load", addr_out, base);
        chk("R2 beat zero", AW'(beat_idx), '0);
        for (int k = 1; k <= 8; k++) begin
          do_adv();
          chk(m[0] ? "R4 interleave" : "R5 linear", addr_out,
              {base[AW-1:2], exp_low(s[1:0], k, m[0])});
          chk("R6 beat", AW'(beat_idx), AW'(k % 4));
          if (k % 4 == 0) chk("R6 wrap", AW'(addr_out[1:0]), AW'(s));
          chk("R9 upper", AW'(addr_out[AW-1:2]), AW'(base[AW-1:2]));
        end
      end
    end

    // R7: hold with advance deasserted.
    order_sel = 1'b0;
    do_load(1'b0, 17'h1abc4 | 17'd2, 1'b0);
    do_adv();
    for (int h = 0; h < 3; h++) begin
      cyc();
      chk("R7 hold addr", addr_out, (17'h1abc4 | 17'd2) + 17'd1);
      chk("R7 hold beat", AW'(beat_idx), 17'd1);
    end

    // R8: load with advance in the same edge.
    do_load(1'b1, 17'h0f0f1, 1'b1);
    chk("R8 priority addr", addr_out, 17'h0f0f1);
    chk("R8 priority beat", AW'(beat_idx), '0);

    // R10: linear from 01, two steps, then switch to interleaved.
    order_sel = 1'b0;
    do_load(1'b0, 17'h02221, 1'b0);
    do_adv();
    do_adv();
    chk("R10 pre-switch", addr_out, 17'h02223);
    order_sel = 1'b1;
    cyc();
    chk("R10 no immediate effect", addr_out, 17'h02223);
    do_adv();
    chk("R10 new order at beat 3", addr_out, 17'h02222);
    chk("R10 beat", AW'(beat_idx), 17'd3);

    // R1: reset mid-burst.
    rst = 1'b1;
    cyc();
    chk("R1 mid-burst addr", addr_out, '0);
    chk("R1 mid-burst beat", AW'(beat_idx), '0);
    rst = 1'b0;
    cyc();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule